// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous host and an asynchronous static RAM of 512K locations by 8 bits. The host hands over one request at a time through a valid/ready handshake. A request carries a read/write flag, a 19-bit address and a write byte. The controller turns each request into a sequence of active-low chip-select, write-strobe and output-enable levels. Every phase lasts a whole number of system clocks, and each count comes from nanosecond parameters divided by the clock period and rounded up.

Each phase gets its own minimum length. A read keeps its strobes asserted until both the address-to-data time and the output-enable-to-data time have passed. After a read, the output enable is raised and the controller waits for the device's turn-off time before it may drive the shared bus. The write pulse must cover the strobe width, the address-to-end setup, the full cycle time and the data setup. Write data stays driven for one hold cycle after the strobes rise. When no request is in progress, the memory is deselected so that it stays in standby.

The data bus is presented as a separate output, output-enable and input so that a pad ring can form the tristate. A parameter keeps output enable low through writes. In that case the driver waits out the turn-off time inside the write pulse before it drives the bus.

Top module: `sramc_top`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1 and `mem_dq_oe` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the last phase of that operation has finished, so only one operation is ever in flight.
- R3: A read asserts `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly max(ceil(T_AA_NS/CLK_NS), ceil(T_DOE_NS/CLK_NS)) cycles, starting the cycle after acceptance. With the defaults this is 7 cycles.
- R4: The read byte is sampled from `mem_dq_in` at the clock edge that ends the last read-strobe cycle. `rsp_valid` is 1 for exactly the following cycle, with that byte on `rsp_rdata`.
- R5: After the read strobes, all three strobes are high, the bus is not driven and `req_ready` stays 0 for ceil(T_HZ_NS/CLK_NS) cycles. With the defaults this is 3 cycles.
- R6: A write (`req_write`=1) asserts `mem_ce_n`=0 and `mem_we_n`=0 with `mem_oe_n`=1 for exactly max of the rounded strobe width, cycle time, address setup and data setup. With the defaults this is 7 cycles, starting the cycle after acceptance.
- R7: During the write pulse and one further hold cycle with all strobes high, `mem_dq_oe` is 1 and `mem_dq_out` carries the accepted byte. The bus is released after the hold cycle.
- R8: `mem_dq_oe` is never 1 while the memory may drive the bus. The bus is released for at least one cycle before `mem_oe_n` falls.
- R9: `mem_addr` equals the accepted address and is stable through every cycle of the operation, including the hold and turnaround phases.
- R10: `rsp_valid` is never 1 during or after a write operation.
- R11: Changes on `req_write`, `req_addr`, `req_wdata` or `req_valid` while `req_ready` is 0 have no effect on `mem_addr`, `mem_dq_out` or the strobes of the operation in progress.
- R12: A request held valid is taken on the first ready cycle. Consecutive acceptances are therefore 11 cycles apart after a read and 9 cycles apart after a write with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Memory location |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte read from memory |
| mem_addr | output | 19 | Address pins of the memory |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach from the ports is a read immediately followed by a write with the request held valid. Here the turnaround gap is the only thing that keeps the controller from driving a bus the memory still owns. The bench holds `req_valid` across busy periods and alternates read and write. Its behavioural memory returns a junk byte until the read strobes have aged the full access count. It also stores a junk byte when a write pulse is short or its data is not held, so phases that are too short show up as wrong read data. Boundary addresses 0 and all-ones, and reads of never-written locations, cover the address path.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD      = 3'd1,
      ST_RD_TURN = 3'd2,
      ST_WR      = 3'd3,
      ST_WR_HOLD = 3'd4
   } sramc_state_e;

   // nanoseconds to whole clocks, rounded up, never less than one
   function automatic int ns_to_clk(input int ns, input int clk_ns);
      if (ns <= 0) return 1;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int RD_CYC   = 7,
   parameter int WR_CYC   = 7,
   parameter int TURN_CYC = 3,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_done,
   output sramc_state_e     state,
   output logic             accept,
   output logic             capture,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val
);

   sramc_state_e state_nx;

   assign accept  = (state == ST_IDLE) && req_valid;
   assign capture = (state == ST_RD) && tmr_done;

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_nx = ST_WR;
                  tmr_val  = CNT_W'(WR_CYC - 1);
               end else begin
                  state_nx = ST_RD;
                  tmr_val  = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_RD: begin
            if (tmr_done) begin
               state_nx = ST_RD_TURN;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(TURN_CYC - 1);
            end
         end
         ST_RD_TURN: begin
            if (tmr_done) state_nx = ST_IDLE;
         end
         ST_WR: begin
            if (tmr_done) state_nx = ST_WR_HOLD;
         end
         ST_WR_HOLD: begin
            state_nx = ST_IDLE;
         end
         default: begin
            state_nx = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rsp_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= capture;
         if (capture) rdata_q <= bus_in;
      end
   end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
   import sramc_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_AA_NS   = 70,
   parameter int T_DOE_NS  = 35,
   parameter int T_PWE_NS  = 50,
   parameter int T_WC_NS   = 70,
   parameter int T_AW_NS   = 60,
   parameter int T_SD_NS   = 30,
   parameter int T_HZ_NS   = 25,
   parameter bit WR_OE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n
);

   localparam int RD_CYC   = imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_DOE_NS, CLK_NS));
   localparam int TURN_CYC = ns_to_clk(T_HZ_NS, CLK_NS);
   localparam int SD_CYC   = ns_to_clk(T_SD_NS, CLK_NS);
   localparam int WR_BASE  = imax(imax(ns_to_clk(T_PWE_NS, CLK_NS), ns_to_clk(T_WC_NS, CLK_NS)),
                                  ns_to_clk(T_AW_NS, CLK_NS));
   localparam int WR_CYC   = WR_OE_LOW ? imax(WR_BASE, TURN_CYC + SD_CYC) : imax(WR_BASE, SD_CYC);
   localparam int DRV_DLY  = WR_OE_LOW ? TURN_CYC : 0;
   localparam int CNT_MAX  = imax(imax(RD_CYC, WR_CYC), TURN_CYC);
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sramc_top: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sramc_top: clock period must be at least 1 ns");
      end
   endgenerate

   sramc_state_e     state;
   logic             accept, capture, tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;
   logic             drive_window;

   sramc_seq #(
      .RD_CYC  (RD_CYC),
      .WR_CYC  (WR_CYC),
      .TURN_CYC(TURN_CYC),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .tmr_done (tmr_done),
      .state    (state),
      .accept   (accept),
      .capture  (capture),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val)
   );

   sramc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .cnt     (tmr_cnt),
      .done    (tmr_done)
   );

   sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .capture  (capture),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .bus_in   (mem_dq_in),
      .addr_q   (mem_addr),
      .wdata_q  (mem_dq_out),
      .rdata_q  (rsp_rdata),
      .rsp_q    (rsp_valid)
   );

   assign req_ready = (state == ST_IDLE);
   assign mem_ce_n  = !((state == ST_RD) || (state == ST_WR));
   assign mem_we_n  = !(state == ST_WR);

   // inside the pulse the driver may start late to let the device turn off
   assign drive_window = (tmr_cnt <= CNT_W'(WR_CYC - 1 - DRV_DLY));
   assign mem_dq_oe    = ((state == ST_WR) && drive_window) || (state == ST_WR_HOLD);

   generate
      if (WR_OE_LOW) begin : g_oe_through_write
         assign mem_oe_n = !((state == ST_RD) || (state == ST_WR));
      end else begin : g_oe_read_only
         assign mem_oe_n = !(state == ST_RD);
      end
   endgenerate

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker
   import sramc_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_AA_NS   = 70,
   parameter int T_DOE_NS  = 35,
   parameter int T_PWE_NS  = 50,
   parameter int T_WC_NS   = 70,
   parameter int T_AW_NS   = 60,
   parameter int T_SD_NS   = 30,
   parameter int T_HZ_NS   = 25,
   parameter bit WR_OE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n
);

   localparam int RD_MIN   = imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_DOE_NS, CLK_NS));
   localparam int TURN_MIN = ns_to_clk(T_HZ_NS, CLK_NS);
   localparam int WR_MIN   = imax(imax(ns_to_clk(T_PWE_NS, CLK_NS), ns_to_clk(T_WC_NS, CLK_NS)),
                                  ns_to_clk(T_AW_NS, CLK_NS));

   logic        dev_drives;
   logic [15:0] rd_len, wr_len, quiet_len;

   assign dev_drives = !mem_ce_n && !mem_oe_n && mem_we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_len    <= '0;
         wr_len    <= '0;
         quiet_len <= 16'hFFFF;
      end else begin
         rd_len    <= dev_drives ? rd_len + 1'b1 : '0;
         wr_len    <= (!mem_ce_n && !mem_we_n) ? wr_len + 1'b1 : '0;
         quiet_len <= dev_drives ? '0 : ((quiet_len == 16'hFFFF) ? quiet_len : quiet_len + 1'b1);
      end
   end

   p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_read_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_drives && rd_len != 0) |-> (rd_len >= 16'(RD_MIN)));

   p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

   p_turn_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (quiet_len >= 16'(TURN_MIN)));

   p_write_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && wr_len != 0) |-> (wr_len >= 16'(WR_MIN)));

   p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && wr_len != 0) |-> (mem_dq_oe && $stable(mem_dq_out)));

   p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dev_drives |-> !mem_dq_oe);

   p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   p_no_rsp_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || mem_dq_oe) |-> !rsp_valid);

   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!WR_OE_LOW && !mem_we_n) |-> mem_oe_n);

endmodule

bind sramc_top sramc_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
   .T_AA_NS(T_AA_NS), .T_DOE_NS(T_DOE_NS), .T_PWE_NS(T_PWE_NS),
   .T_WC_NS(T_WC_NS), .T_AW_NS(T_AW_NS), .T_SD_NS(T_SD_NS),
   .T_HZ_NS(T_HZ_NS), .WR_OE_LOW(WR_OE_LOW)
) u_sramc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_dq_out(mem_dq_out),
   .mem_dq_oe (mem_dq_oe),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n)
);

// File: tb/test_sramc_top.sv
module test_sramc_top;

   localparam int RD   = 7;   // read strobe cycles (R3)
   localparam int TURN = 3;   // turnaround cycles (R5)
   localparam int WR   = 7;   // write pulse cycles (R6)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
   logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
   logic [18:0] mem_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   sramc_top i_sramc_top (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got=%h exp=%h (cycle %0d)", tag, what, got, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [7:0] init_byte(input logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
   endfunction

   // ---------------- behavioural memory on the pins ----------------
   logic [7:0]  sram_mem [int];
   int          rd_age = 0;
   int          wr_age = 0;
   logic [18:0] pend_a = '0;
   logic [7:0]  pend_d = '0;

   function automatic logic [7:0] sram_rd(input logic [18:0] a);
      if (sram_mem.exists(int'(a))) return sram_mem[int'(a)];
      return init_byte(a);
   endfunction

   // junk until the strobes have been low for the full access time
   assign mem_dq_in = (rd_age >= RD - 1) ? sram_rd(mem_addr) : 8'hA5;

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n) begin
         wr_age <= wr_age + 1;
         pend_a <= mem_addr;
         pend_d <= mem_dq_oe ? mem_dq_out : 8'h5A;
      end else begin
         if (wr_age != 0) begin
            if (wr_age >= WR && mem_dq_oe && mem_dq_out == pend_d && mem_addr == pend_a)
               sram_mem[int'(pend_a)] = pend_d;
            else
               sram_mem[int'(pend_a)] = 8'h5A;
         end
         wr_age <= 0;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
      else                                    rd_age <= 0;
   end

   // ---------------- cycle reference model ----------------
   int          m_kind = 0;   // 0 idle, 1 read, 2 write
   int          m_t = 0;
   logic [18:0] m_addr = '0;
   logic [7:0]  m_data = '0;
   logic [7:0]  m_ref [int];
   bit          acc_pulse = 0;
   int          last_acc = 0;

   function automatic logic [7:0] ref_rd(input logic [18:0] a);
      if (m_ref.exists(int'(a))) return m_ref[int'(a)];
      return init_byte(a);
   endfunction

   always @(posedge clk) begin
      cyc++;
      acc_pulse = 0;
      if (!rst_n) begin
         m_kind = 0;
         m_t    = 0;
      end else if (m_kind == 0) begin
         if (req_valid) begin
            m_kind    = req_write ? 2 : 1;
            m_t       = 1;
            m_addr    = req_addr;
            m_data    = req_wdata;
            acc_pulse = 1;
            last_acc  = cyc;
            if (req_write) m_ref[int'(req_addr)] = req_wdata;
         end
      end else begin
         m_t++;
         if (m_t > ((m_kind == 1) ? RD + TURN : WR + 1)) m_kind = 0;
      end
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   // per-cycle comparison, away from the active edge
   logic prev_oe_n = 1'b1;
   logic prev_dq_oe = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic e_rdy, e_ce, e_we, e_oe, e_drv, e_rsp;
         string tag;
         e_rdy = (m_kind == 0);
         e_ce = 1; e_we = 1; e_oe = 1; e_drv = 0; e_rsp = 0;
         tag = "R1";
         if (m_kind == 1) begin
            if (m_t <= RD) begin e_ce = 0; e_oe = 0; tag = "R3"; end
            else tag = "R5";
            e_rsp = (m_t == RD + 1);
         end else if (m_kind == 2) begin
            if (m_t <= WR) begin e_ce = 0; e_we = 0; tag = "R6"; end
            else tag = "R7";
            e_drv = 1;
         end
         chk("R2", "req_ready", req_ready, e_rdy);
         chk(tag, "mem_ce_n", mem_ce_n, e_ce);
         chk(tag, "mem_we_n", mem_we_n, e_we);
         chk(tag, "mem_oe_n", mem_oe_n, e_oe);
         chk((m_kind == 2) ? "R7" : "R8", "mem_dq_oe", mem_dq_oe, e_drv);
         chk((m_kind == 2) ? "R10" : "R4", "rsp_valid", rsp_valid, e_rsp);
         if (e_rsp) chk("R4", "rsp_rdata", rsp_rdata, ref_rd(m_addr));
         if (m_kind != 0) chk("R9", "mem_addr", mem_addr, m_addr);
         if (e_drv) chk("R7", "mem_dq_out", mem_dq_out, m_data);
         if (!mem_oe_n && prev_oe_n)
            chk("R8", "bus driven before oe fall", prev_dq_oe, 1'b0);
         prev_oe_n  = mem_oe_n;
         prev_dq_oe = mem_dq_oe;
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      do @(negedge clk); while (!acc_pulse);
      // R11: scramble the request inputs while the operation runs
      req_valid = 1'b0;
      req_write = ~w;
      req_addr  = ~a;
      req_wdata = ~d;
      @(negedge clk);
      chk("R11", "mem_addr after input change", mem_addr, a);
      if (w) chk("R11", "mem_dq_out after input change", mem_dq_out, d);
      chk("R11", "mem_we_n after input change", mem_we_n, !w);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_kind != 0);
      @(negedge clk);
   endtask

   initial begin
      int a0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);   // R1 idle state checked by the compare loop

      issue(1'b1, 19'h00000, 8'h3C);
      wait_idle();
      issue(1'b0, 19'h00000, 8'h00);
      wait_idle();

      // R12: write then read held back to back at the top address
      issue(1'b1, 19'h7FFFF, 8'hC3);
      a0 = last_acc;
      issue(1'b0, 19'h7FFFF, 8'h00);
      chk("R12", "gap after write", last_acc - a0, 9);
      wait_idle();

      // R12: read of an unwritten location, read again, write, read
      issue(1'b0, 19'h12345, 8'h00);
      a0 = last_acc;
      issue(1'b0, 19'h12345, 8'h00);
      chk("R12", "gap after read", last_acc - a0, 11);
      issue(1'b1, 19'h12345, 8'h99);   // write right after a read: turnaround R5/R8
      issue(1'b0, 19'h12345, 8'h00);
      wait_idle();

      for (int i = 0; i < 16; i++) issue(1'b1, 19'(i * 32'h1111), 8'(i * 17 + 1));
      for (int i = 15; i >= 0; i--) issue(1'b0, 19'(i * 32'h1111), 8'h00);
      wait_idle();

      for (int i = 0; i < 8; i++) begin
         issue(1'b1, 19'(32'h40000 + i), 8'(8'hF0 ^ i));
         issue(1'b0, 19'(32'h40000 + i), 8'h00);
      end
      wait_idle();
      repeat (3) @(negedge clk);
      summary();
   end

endmodule